// File: doc/BRIEF.md
# Dual-Mode Serial Result Output Port

This block sends a 16-bit conversion result, most significant bit first, on a single serial data line. It keeps the last result word handed over by the conversion sequencer and shifts it out in one of two modes, chosen by a mode input. In internal-clock mode the block makes its own burst of data-clock pulses each time a conversion begins, so the host receives the previous result while the new conversion runs. In external-clock mode the host supplies the data clock and frames a read with chip select and read/convert. The block can also place a one-period frame-sync pulse in front of the word, and that pulse moves the first data bit one clock later.

All logic runs on one system clock. The host-side pins (chip select, read/convert, external data clock) pass through a synchronizer, and the block acts on edges of the external data clock that it detects in the system clock domain. The internal data clock is made by dividing the system clock. The divider parameter should be set so that all 16 bits go out within the first half of the conversion's busy-low period.

Top module: `sp_result_port`

## Requirements
- R1: After reset, sdata, sclk_out and sync_out are all 0.
- R2: With mode_ext = 0, a falling edge on busy starts one burst of exactly 16 pulses on sclk_out, provided pwr_dn is 0. The burst carries the held word MSB first, sampled on each rising edge. A busy fall during an active burst is ignored. sclk_oe is 1 when mode_ext = 0 and 0 when mode_ext = 1, and sclk_out stays 0 in external mode.
- R3: In internal mode, sdata changes only while sclk_out is low, so each bit is stable on both the rising and the falling edge of its pulse. After the 16th pulse, sclk_out stays low until the next burst.
- R4: With mode_ext = 1, the read window is open while cs_n = 0 and rd_cvt = 1. Opening the window takes a snapshot of the held word. Without frame sync, the 1st rising edge of ext_sclk inside the window puts the MSB on sdata, the 16th puts the LSB there, and each bit holds across the following falling edge. sdata does not change while the window is closed.
- R5: Any ext_sclk edge while the window is closed (cs_n = 1, or cs_n = 0 with rd_cvt = 0) arms frame sync. The 1st rising edge inside the window then raises sync_out for exactly one ext_sclk period. The MSB follows on the 2nd rising edge and the LSB on the 17th.
- R6: When frame sync is not armed, sync_out stays 0 for the whole read.
- R7: The held word is the one from the last load strobe, passed unchanged in straight binary (0xFFFF, 0x8000 and 0x0000 come out as written). A read made before the new load (busy low) returns the previous result. A read made after the load returns the new one.
- R8: After the last bit, sdata keeps the LSB while no clock edges arrive. Each further rising edge of ext_sclk shifts out a 0.
- R9: While pwr_dn = 1, load strobes are ignored and a busy fall starts no burst, but an external-mode read still returns the stored word.
- R10: A load strobe that arrives while a word is being shifted out, in either mode, does not change that word. The next transfer carries the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ext | input | 1 | 0 = internal data clock, 1 = external data clock |
| pwr_dn | input | 1 | Power-down: blocks loads and bursts |
| cs_n | input | 1 | Chip select, active low (host pin, asynchronous) |
| rd_cvt | input | 1 | 1 = read, 0 = convert (host pin, asynchronous) |
| ext_sclk | input | 1 | Data clock from the host in external mode |
| busy | input | 1 | Conversion busy, low while converting (sequencer, synchronous) |
| ld | input | 1 | Load strobe for the result word |
| result | input | WIDTH | Parallel conversion result |
| sdata | output | 1 | Serial data, MSB first |
| sclk_out | output | 1 | Generated data clock in internal mode |
| sclk_oe | output | 1 | High when the block drives the data clock |
| sync_out | output | 1 | Frame-sync pulse in external mode |

## Verification
A load strobe from the sequencer and an active shift can land on the same cycle: a new result can arrive while the previous word is still going out. The bench raises the load strobe in the middle of an internal burst and again between two external clock pulses of a read. The check passes if the outgoing word finishes bit-exact and the next transfer carries the new word. In the same way, a frame-sync arming edge and the opening of the read window fall close together, and the bench checks that the sync pulse takes exactly one clock period before the MSB.

// File: rtl/sp_pkg.sv
// Shared types for the serial result port.
package sp_pkg;
    // Quarter-period phases of one internal data-clock bit period.
    typedef enum logic [1:0] {
        PH_SET  = 2'd0,   // present next bit, clock low
        PH_RISE = 2'd1,   // raise clock
        PH_HIGH = 2'd2,   // hold clock high
        PH_FALL = 2'd3    // drop clock
    } burst_ph_e;
endpackage

// File: rtl/sp_pin_sync.sv
// sp_pin_sync: multi-stage synchronizer for one asynchronous host pin.
// Assumes STAGES >= 2; INIT is the idle level loaded at reset.
module sp_pin_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_int_burst.sv
// sp_int_burst: internal data-clock generator and shifter.
// On start it sends WIDTH bits MSB first with WIDTH clock pulses. Each bit
// period has four phases of CLK_DIV system cycles each, so data moves only
// while the clock is low. A start during an active burst is ignored.
module sp_int_burst
    import sp_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int CLK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] word,
    output logic             sclk,
    output logic             sdata,
    output logic             active
);
    localparam int PRE_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] bitcnt;
    logic [WIDTH-1:0] sr;
    burst_ph_e        phase;
    logic             tick;

    assign tick = (pre == PRE_MAX);

    // Run the burst: prescale, step phases, shift bits, count pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre    <= '0;
            bitcnt <= '0;
            sr     <= '0;
            phase  <= PH_SET;
            sclk   <= 1'b0;
            sdata  <= 1'b0;
            active <= 1'b0;
        end else if (start && !active) begin
            pre    <= '0;
            bitcnt <= '0;
            sdata  <= word[WIDTH-1];
            sr     <= {word[WIDTH-2:0], 1'b0};
            phase  <= PH_RISE;
            sclk   <= 1'b0;
            active <= 1'b1;
        end else if (active) begin
            if (tick) begin
                pre <= '0;
                case (phase)
                    PH_SET: begin
                        sdata <= sr[WIDTH-1];
                        sr    <= {sr[WIDTH-2:0], 1'b0};
                        phase <= PH_RISE;
                    end
                    PH_RISE: begin
                        sclk  <= 1'b1;
                        phase <= PH_HIGH;
                    end
                    PH_HIGH: phase <= PH_FALL;
                    PH_FALL: begin
                        sclk <= 1'b0;
                        if (bitcnt == LAST_BIT) begin
                            active <= 1'b0;
                            phase  <= PH_SET;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            phase  <= PH_SET;
                        end
                    end
                endcase
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_ext_shift.sv
// sp_ext_shift: external-clock framer and shifter.
// Assumes win, win_open, x_rise and x_edge come from synchronized host pins.
// A clock edge outside the read window arms frame sync. Opening the window
// snapshots the word. Rising edges inside the window emit the sync pulse
// (if armed) and then the bits, with zeros shifted in behind them.
module sp_ext_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             win,
    input  logic             win_open,
    input  logic             x_rise,
    input  logic             x_edge,
    input  logic [WIDTH-1:0] word,
    output logic             sdata,
    output logic             sync,
    output logic             armed
);
    logic [WIDTH-1:0] sr;

    // Arm, snapshot and shift on synchronized external clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            sdata <= 1'b0;
            sync  <= 1'b0;
            armed <= 1'b0;
        end else if (!enable) begin
            sync  <= 1'b0;
            armed <= 1'b0;
        end else if (!win) begin
            sync <= 1'b0;
            if (x_edge) armed <= 1'b1;
        end else if (win_open) begin
            sr   <= word;
            sync <= 1'b0;
        end else if (x_rise) begin
            if (armed) begin
                sync  <= 1'b1;
                armed <= 1'b0;
            end else begin
                sync  <= 1'b0;
                sdata <= sr[WIDTH-1];
                sr    <= {sr[WIDTH-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sp_result_port.sv
// sp_result_port: dual-mode serial result output port (top).
// Keeps the last loaded result and sends it either with its own burst
// clock (mode_ext = 0, started by a busy fall) or with a host clock
// (mode_ext = 1, framed by cs_n / rd_cvt). busy, ld and result are
// synchronous to clk; cs_n, rd_cvt and ext_sclk are asynchronous.
module sp_result_port #(
    parameter int WIDTH       = 16,
    parameter int CLK_DIV     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ext,
    input  logic             pwr_dn,
    input  logic             cs_n,
    input  logic             rd_cvt,
    input  logic             ext_sclk,
    input  logic             busy,
    input  logic             ld,
    input  logic [WIDTH-1:0] result,
    output logic             sdata,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             sync_out
);
    localparam int NPIN = 3;                       // cs_n, rd_cvt, ext_sclk
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b011; // idle levels at reset

    logic [NPIN-1:0]  pins_raw;
    logic [NPIN-1:0]  pins_s;
    logic [WIDTH-1:0] res_q;
    logic             busy_q;
    logic             xclk_q;
    logic             win, win_q, win_open;
    logic             x_rise, x_edge;
    logic             conv_start;
    logic             burst_act, int_sclk, int_sd;
    logic             ext_sd, ext_sync, ext_armed;

    assign pins_raw = {ext_sclk, rd_cvt, cs_n};

    // One synchronizer per host pin.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        sp_pin_sync #(.STAGES(SYNC_STAGES), .INIT(PIN_IDLE[g])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pins_raw[g]),
            .q    (pins_s[g])
        );
    end

    // Hold the result word; loads are blocked in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)               res_q <= '0;
        else if (ld && !pwr_dn)   res_q <= result;
    end

    // Delay registers for busy, external clock and read-window edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            xclk_q <= 1'b0;
            win_q  <= 1'b0;
        end else begin
            busy_q <= busy;
            xclk_q <= pins_s[2];
            win_q  <= win;
        end
    end

    assign win        = ~pins_s[0] & pins_s[1];
    assign win_open   = win & ~win_q;
    assign x_rise     = pins_s[2] & ~xclk_q;
    assign x_edge     = pins_s[2] ^ xclk_q;
    assign conv_start = busy_q & ~busy & ~mode_ext & ~pwr_dn;

    sp_int_burst #(.WIDTH(WIDTH), .CLK_DIV(CLK_DIV)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .word  (res_q),
        .sclk  (int_sclk),
        .sdata (int_sd),
        .active(burst_act)
    );

    sp_ext_shift #(.WIDTH(WIDTH)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode_ext),
        .win     (win),
        .win_open(win_open),
        .x_rise  (x_rise),
        .x_edge  (x_edge),
        .word    (res_q),
        .sdata   (ext_sd),
        .sync    (ext_sync),
        .armed   (ext_armed)
    );

    // Select the active mode's outputs.
    always_comb begin
        sdata    = mode_ext ? ext_sd : int_sd;
        sclk_out = ~mode_ext & int_sclk;
        sclk_oe  = ~mode_ext;
        sync_out = ext_sync;
    end
endmodule

// File: rtl/sp_result_port_chk.sv
// sp_result_port_chk: temporal checks on the serial result port, bound to
// the top. Assumes a synchronous active-low reset.
module sp_result_port_chk #(
    parameter int WIDTH = 16
) (
    input logic clk,
    input logic rst_n,
    input logic mode_ext,
    input logic pwr_dn,
    input logic sdata,
    input logic sclk_out,
    input logic sync_out,
    input logic win,
    input logic x_rise,
    input logic burst_act
);
    localparam int PC_W = $clog2(WIDTH) + 2;

    logic            sclk_q;
    logic [PC_W-1:0] pcnt;

    // Count generated clock pulses within one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            pcnt   <= '0;
        end else begin
            sclk_q <= sclk_out;
            if (!burst_act)                 pcnt <= '0;
            else if (sclk_out && !sclk_q)   pcnt <= pcnt + 1'b1;
        end
    end

    assert_pulse_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && sclk_out && !sclk_q) |-> (pcnt < PC_W'(WIDTH)));

    assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ext && !$past(mode_ext) && (sclk_out || $past(sclk_out))) |-> $stable(sdata));

    assert_no_shift_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ext && $past(mode_ext) && !$past(win)) |-> $stable(sdata));

    assert_sync_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(win));

    assert_sync_one_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && x_rise) |=> !sync_out);

    assert_pd_no_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_dn) && !$past(burst_act)) |-> !burst_act);
endmodule

bind sp_result_port sp_result_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_ext (mode_ext),
    .pwr_dn   (pwr_dn),
    .sdata    (sdata),
    .sclk_out (sclk_out),
    .sync_out (sync_out),
    .win      (win),
    .x_rise   (x_rise),
    .burst_act(burst_act)
);

// File: tb/sim_sp_result_port.sv
`timescale 1ns/1ps
// sim_sp_result_port: self-checking bench for the serial result port.
module sim_sp_result_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ext = 1'b0, pwr_dn = 1'b0;
    logic        cs_n = 1'b1, rd_cvt = 1'b1, ext_sclk = 1'b0;
    logic        busy = 1'b1, ld = 1'b0;
    logic [15:0] result = '0;
    logic        sdata, sclk_out, sclk_oe, sync_out;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [17:0] vec_cur;

    // Vector: {mode_ext, arm_sync, word}
    localparam logic [17:0] VEC [0:6] = '{
        {1'b0, 1'b0, 16'hFFFF},   // full scale minus 1 LSB
        {1'b0, 1'b0, 16'h8000},   // midscale
        {1'b0, 1'b0, 16'h0000},   // minus full scale
        {1'b1, 1'b0, 16'hA55A},
        {1'b1, 1'b1, 16'h1234},
        {1'b1, 1'b1, 16'h8001},
        {1'b1, 1'b0, 16'h0001}
    };

    always #10 clk = ~clk;   // 50 MHz

    sp_result_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .pwr_dn(pwr_dn),
        .cs_n(cs_n), .rd_cvt(rd_cvt), .ext_sclk(ext_sclk), .busy(busy),
        .ld(ld), .result(result), .sdata(sdata), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .sync_out(sync_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ld(input logic [15:0] w);
        @(negedge clk); ld = 1'b1; result = w;
        @(negedge clk); ld = 1'b0;
    endtask

    task automatic xedge(input logic v);
        @(negedge clk); ext_sclk = v;
        idle_cycles(6);
    endtask

    // Internal mode: start a burst with a busy fall and capture it.
    task automatic run_int(input logic [15:0] w, input int exp_n, input bit mid, input logic [15:0] w2);
        logic [15:0] cap = '0;
        int  n = 0, unsteady = 0;
        bit  prev = 1'b0, last = 1'b0;
        chk(sclk_oe == 1'b1, "R2 clock driven in internal mode", 32'(sclk_oe), 32'd1);
        @(negedge clk); busy = 1'b0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (mid && c == 40) begin ld = 1'b1; result = w2; end
            if (mid && c == 41) ld = 1'b0;
            if (c == 150) busy = 1'b1;
            if (sclk_out && !prev) begin
                if (n < 16) cap[15-n] = sdata;
                last = sdata;
                n++;
            end else if (!sclk_out && prev && sdata != last) begin
                unsteady++;
            end
            prev = sclk_out;
        end
        chk(n == exp_n, "R2 pulse count", 32'(n), 32'(exp_n));
        if (exp_n > 0) begin
            chk(cap == w, mid ? "R10 word kept over load" : "R2 word MSB first", 32'(cap), 32'(w));
            chk(unsteady == 0, "R3 bit steady on both edges", 32'(unsteady), 32'd0);
        end
        chk(sclk_out == 1'b0, "R3 clock idles low", 32'(sclk_out), 32'd0);
    endtask

    // External mode: frame a read, optionally arm sync and load mid-word.
    task automatic run_ext(input logic [15:0] w, input bit arm, input bit mid, input logic [15:0] w2);
        logic [15:0] cap = '0;
        int sync_hits = 0, drift = 0;
        chk({sclk_oe, sclk_out} == 2'b00, "R2 clock released in external mode", 32'({sclk_oe, sclk_out}), 32'd0);
        @(negedge clk); rd_cvt = 1'b0;
        idle_cycles(4);
        cs_n = 1'b0;
        idle_cycles(4);
        if (arm) begin xedge(1'b1); xedge(1'b0); end
        rd_cvt = 1'b1;
        idle_cycles(6);
        chk(sync_out == 1'b0, "R5 no sync before first pulse", 32'(sync_out), 32'd0);
        if (arm) begin
            xedge(1'b1);
            chk(sync_out == 1'b1, "R5 sync after pulse one", 32'(sync_out), 32'd1);
            xedge(1'b0);
            chk(sync_out == 1'b1, "R5 sync held through falling edge", 32'(sync_out), 32'd1);
        end
        for (int i = 0; i < 16; i++) begin
            xedge(1'b1);
            cap[15-i] = sdata;
            if (sync_out) sync_hits++;
            xedge(1'b0);
            if (sdata != cap[15-i]) drift++;
            if (mid && i == 7) pulse_ld(w2);
        end
        chk(cap == w, mid ? "R10 word kept over load" : (arm ? "R5 framed word" : "R4 word MSB first"), 32'(cap), 32'(w));
        chk(sync_hits == 0, arm ? "R5 sync one period" : "R6 no sync unarmed", 32'(sync_hits), 32'd0);
        chk(drift == 0, "R4 bit held across falling edge", 32'(drift), 32'd0);
        idle_cycles(20);
        chk(sdata == w[0], "R8 last bit held", 32'(sdata), 32'(w[0]));
        xedge(1'b1); xedge(1'b0);
        chk(sdata == 1'b0, "R8 extra clock shifts zero", 32'(sdata), 32'd0);
        @(negedge clk); cs_n = 1'b1;
        idle_cycles(6);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_cycles(5);
        rst_n = 1'b1;
        idle_cycles(3);
        chk({sdata, sclk_out, sync_out} == 3'b000, "R1 reset outputs", 32'({sdata, sclk_out, sync_out}), 32'd0);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            vec_cur = VEC[i];
            @(negedge clk); mode_ext = vec_cur[17];
            idle_cycles(4);
            pulse_ld(vec_cur[15:0]);
            if (!vec_cur[17]) run_int(vec_cur[15:0], 16, 1'b0, 16'h0);
            else              run_ext(vec_cur[15:0], vec_cur[16], 1'b0, 16'h0);
        end

        // R7 / R10 internal: burst sends held word, mid-burst load waits
        @(negedge clk); mode_ext = 1'b0;
        idle_cycles(4);
        pulse_ld(16'h1357);
        run_int(16'h1357, 16, 1'b1, 16'h2468);
        run_int(16'h2468, 16, 1'b0, 16'h0);

        // R7 external: previous result during conversion, new after load
        @(negedge clk); mode_ext = 1'b1; busy = 1'b0;
        idle_cycles(4);
        run_ext(16'h2468, 1'b0, 1'b0, 16'h0);
        pulse_ld(16'h9ABC);
        @(negedge clk); busy = 1'b1;
        run_ext(16'h9ABC, 1'b0, 1'b0, 16'h0);

        // R10 external: load in the middle of a framed read
        run_ext(16'h9ABC, 1'b1, 1'b1, 16'h0F0F);
        run_ext(16'h0F0F, 1'b0, 1'b0, 16'h0);

        // R9 power-down: load ignored, read still works, no burst
        @(negedge clk); pwr_dn = 1'b1;
        pulse_ld(16'hDEAD);
        run_ext(16'h0F0F, 1'b0, 1'b0, 16'h0);
        @(negedge clk); mode_ext = 1'b0;
        idle_cycles(4);
        run_int(16'h0F0F, 0, 1'b0, 16'h0);
        @(negedge clk); pwr_dn = 1'b0;
        run_int(16'h0F0F, 16, 1'b0, 16'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule